// File: doc/BRIEF.md
# FIFO-Backed Fixed Delay Line

This block delays a stream of data words by a fixed number of clock cycles set by the `DEPTH` parameter. It is used to line up a data path with a parallel processing branch whose result arrives a known number of cycles later, as in feed-forward correction, where the raw sample must meet its correction term. Storage is a circular RAM with separate write and read pointers rather than a chain of `DEPTH` registers. A long delay therefore costs one memory, two pointers and a small counter instead of `DEPTH` x `DATA_W` flip-flops.

A single active-low control input, `clr_n`, is sampled on the clock. While it is low, the block clears its fill counter and FIFO pointers and forces the output to zero. While it is high, the block writes one word every cycle. Once the fill counter has counted the programmed latency, it also reads one word every cycle, so the FIFO occupancy stays fixed from then on.

The stream moves exactly one word per clock and has no valid/ready handshake. A fixed delay line cannot stall, so there is no back-pressure: the upstream source must present a word every cycle, and the downstream sink must accept `dout` every cycle.

Top module: `fifo_delay_line`

## Requirements
- R1: With `clr_n` high at rising edges k through k+DEPTH-2, the `din` word sampled at edge k is on `dout` from edge k+DEPTH-1 to the next edge. That is a latency of exactly DEPTH cycles, counting the input register, the request register and the RAM read register.
- R2: If `clr_n` is sampled low at edge k, `dout` is zero from edge k+1 onward, and no word sampled before the clear ever appears on `dout` again.
- R3: After a clear, `dout` stays zero through the fill. If k is the first edge that samples `clr_n` high, the first nonzero-capable output is the word sampled at edge k, and it appears at edge k+DEPTH-1.
- R4: The fill counter requests a write from the first high sample. It holds the read request off until DEPTH-1 high samples have been taken. From then on, read and write are requested together every cycle until the next clear.
- R5: Write and read requests are registered outputs of the control stage. Both are deasserted, and the FIFO clear is asserted, in the cycle after `clr_n` is sampled low.
- R6: The FIFO never reads while empty and never writes while full. Its capacity is 2^ADDR_W words, which is strictly greater than DEPTH, and its word width equals DATA_W.
- R7: DEPTH must be at least 4 and 2^ADDR_W must exceed DEPTH; other values stop elaboration. The minimum DEPTH of 4 delays by exactly 4 cycles.
- R8: A clear lasting a single sampled cycle is enough. It zeroes `dout` on the next edge and restarts the fill exactly as a long clear does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Sampled control: low clears the delay line, high lets it run |
| din | input | DATA_W | Data word entering the delay line, one per cycle |
| dout | output | DATA_W | Data word leaving the delay line, DEPTH cycles later |

## Verification
Two instances, one at the default delay of 24 and one at the minimum delay of 4, are driven with the same stimulus and compared on every cycle with a history-based model.

The input patterns serve different purposes:
- An incrementing ramp pins the exact latency, since an off-by-one shows up as a neighbouring value.
- A run of all zeros shows that the zero forced during fill is not mistaken for real data.
- Alternating and scrambled words expose a dropped or reordered RAM slot.
- A constant 0xFF shows whether any bit is stuck.

Clears are applied during steady state, in the middle of a fill, and as single-cycle pulses. These separate the control-stage timing from the RAM-path timing.

// File: rtl/fdl_pkg.sv
package fdl_pkg;

  // Registered request bundle from the control stage to the FIFO.
  typedef struct packed {
    logic clr;  // synchronous FIFO clear
    logic wr;   // write one word
    logic rd;   // read one word
  } fdl_req_t;

endpackage

// File: rtl/fdl_ctrl.sv
module fdl_ctrl
  import fdl_pkg::*;
#(
  parameter int DEPTH = 24
) (
  input  logic     clk,
  input  logic     clr_n,
  output fdl_req_t req
);

  localparam int CW = $clog2(DEPTH);
  localparam logic [CW-1:0] FILL_LAST = CW'(DEPTH - 2);

  logic [CW-1:0] fill_cnt;

  // Fill counter: write only until the latency has built up, then write and read together.
  always_ff @(posedge clk) begin
    if (!clr_n) begin
      fill_cnt <= '0;
      req      <= '{clr: 1'b1, wr: 1'b0, rd: 1'b0};
    end else if (fill_cnt < FILL_LAST) begin
      fill_cnt <= fill_cnt + 1'b1;
      req      <= '{clr: 1'b0, wr: 1'b1, rd: 1'b0};
    end else begin
      req      <= '{clr: 1'b0, wr: 1'b1, rd: 1'b1};
    end
  end

  // R5: a low sample drops both requests and clears the FIFO on the next cycle
  a_r5_clear_drops_req: assert property (@(posedge clk)
    !clr_n |=> (req.clr && !req.wr && !req.rd));

  // R4: a read is never requested without a write
  a_r4_rd_with_wr: assert property (@(posedge clk) disable iff (!clr_n)
    req.rd |-> req.wr);

  // R4: once reading has started it continues while running
  a_r4_rd_sticky: assert property (@(posedge clk) disable iff (!clr_n)
    req.rd |=> req.rd);

  // R4: the first write after a clear comes without a read
  a_r4_fill_no_read: assert property (@(posedge clk) disable iff (!clr_n)
    (req.clr && clr_n) |=> (req.wr && !req.rd));

endmodule

// File: rtl/fdl_ram_fifo.sv
module fdl_ram_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [ADDR_W-1:0] wp;
  logic [ADDR_W-1:0] rp;
  logic [ADDR_W-1:0] occ;

  assign occ = wp - rp;

  always_ff @(posedge clk) begin
    if (wr && !clr) begin
      mem[wp] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wp    <= '0;
      rp    <= '0;
      rdata <= '0;
    end else begin
      if (wr) begin
        wp <= wp + 1'b1;
      end
      if (rd) begin
        rp    <= rp + 1'b1;
        rdata <= mem[rp];
      end
    end
  end

  // R6: no read from an empty FIFO
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (clr)
    rd |-> (occ != '0));

  // R6: no write into a full FIFO
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (clr)
    (wr && !rd) |-> (occ != '1));

  // R2: a clear zeroes the output word
  a_r2_clear_zeroes: assert property (@(posedge clk)
    clr |=> (rdata == '0));

endmodule

// File: rtl/fifo_delay_line.sv
module fifo_delay_line
  import fdl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  // R7: reject an unusable configuration at elaboration
  generate
    if (DEPTH < 4) begin : g_bad_depth
      initial $fatal(1, "fifo_delay_line: DEPTH must be at least 4");
    end
    if ((1 << ADDR_W) <= DEPTH) begin : g_bad_capacity
      initial $fatal(1, "fifo_delay_line: FIFO capacity must exceed DEPTH");
    end
  endgenerate

  logic [DATA_W-1:0] din_q;
  fdl_req_t          req;

  // Input register: retimes the data path onto the clock.
  always_ff @(posedge clk) begin
    din_q <= din;
  end

  fdl_ctrl #(
    .DEPTH (DEPTH)
  ) ctrl_i (
    .clk   (clk),
    .clr_n (clr_n),
    .req   (req)
  );

  fdl_ram_fifo #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) fifo_i (
    .clk   (clk),
    .clr   (req.clr),
    .wr    (req.wr),
    .rd    (req.rd),
    .wdata (din_q),
    .rdata (dout)
  );

  // R2: two low samples in a row leave the output at zero
  a_r2_held_clear_zero: assert property (@(posedge clk)
    (!clr_n && $past(!clr_n)) |=> (dout == '0));

endmodule

// File: tb/fifo_delay_line_tb_top.sv
module fifo_delay_line_tb_top;

  localparam int W    = 8;
  localparam int D    = 24;
  localparam int DMIN = 4;
  localparam int HN   = 8192;
  localparam int NSEG = 10;

  // Segment: {run, kind[1:0], len[7:0], seed[7:0]}
  // kind 0 ramp, 1 constant, 2 alternating, 3 scrambled
  localparam logic [18:0] SEG [NSEG] = '{
    {1'b0, 2'd1, 8'd4,  8'h00},
    {1'b1, 2'd0, 8'd60, 8'h01},
    {1'b1, 2'd2, 8'd40, 8'h5A},
    {1'b0, 2'd1, 8'd3,  8'h77},
    {1'b1, 2'd1, 8'd30, 8'hFF},
    {1'b1, 2'd3, 8'd50, 8'h3C},
    {1'b0, 2'd1, 8'd1,  8'hAA},
    {1'b1, 2'd0, 8'd12, 8'h80},
    {1'b0, 2'd1, 8'd2,  8'h11},
    {1'b1, 2'd1, 8'd40, 8'h00}
  };

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic [W-1:0] dout_min;

  always #4 clk = ~clk;

  fifo_delay_line #(.DATA_W(W), .DEPTH(D), .ADDR_W(10)) dut_i (
    .clk (clk), .clr_n (clr_n), .din (din), .dout (dout)
  );

  fifo_delay_line #(.DATA_W(W), .DEPTH(DMIN), .ADDR_W(3)) dut_min_i (
    .clk (clk), .clr_n (clr_n), .din (din), .dout (dout_min)
  );

  logic         hc [HN];
  logic [W-1:0] hd [HN];
  int n = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic logic [W-1:0] model(int e, int dd);
    logic ok = 1'b1;
    if (e - dd + 1 < 0) return '0;
    for (int j = e - dd + 1; j <= e - 1; j++) begin
      if (!hc[j]) ok = 1'b0;
    end
    return ok ? hd[e - dd + 1] : '0;
  endfunction

  function automatic logic [W-1:0] pattern(logic [1:0] kind, logic [7:0] seed, int i);
    case (kind)
      2'd0: return W'(seed + i);
      2'd1: return seed;
      2'd2: return i[0] ? ~seed : seed;
      default: return W'((seed * 37) ^ (i * 13));
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s edge %0d: actual %02h expected %02h", req, n, act, exp);
    end
  endtask

  // Drive one word, record what the edge samples, compare both instances after it.
  task automatic step(logic c, logic [W-1:0] d);
    logic [W-1:0] e_main;
    logic [W-1:0] e_min;
    clr_n = c;
    din   = d;
    @(posedge clk);
    hc[n] = c;
    hd[n] = d;
    @(negedge clk);
    if (n >= 2) begin
      e_main = model(n, D);
      e_min  = model(n, DMIN);
      check(e_main == '0 ? "R2 R3 R4" : "R1 R5 R6", dout, e_main);
      check("R7 min depth", dout_min, e_min);
    end
    n++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    int kc;
    int first;
    // Vector table walk
    for (int s = 0; s < NSEG; s++) begin
      for (int i = 0; i < int'(SEG[s][15:8]); i++) begin
        step(SEG[s][18], pattern(SEG[s][17:16], SEG[s][7:0], i));
      end
      if (s == 0) begin
        check("R2 reset state", dout, '0);
        check("R2 reset state min", dout_min, '0);
      end
    end

    // Directed: single-cycle clear in steady state
    for (int i = 0; i < D + 4; i++) step(1'b1, W'(8'h40 + i));
    kc = n;
    step(1'b0, 8'hEE);
    first = n;
    step(1'b1, 8'hC3);
    check("R8 zero after one-cycle clear", dout, '0);
    for (int i = 1; i < D - 1; i++) step(1'b1, W'(8'hC3 + i));
    check("R8 still filling", dout, '0);
    step(1'b1, 8'h99);
    check("R8 first word after refill", dout, hd[first]);
    check("R8 clear edge recorded low", W'(hc[kc]), '0);

    // Directed: clear in the middle of a fill, then a full-length run
    for (int i = 0; i < D / 2; i++) step(1'b1, W'(i + 1));
    step(1'b0, 8'h01);
    for (int i = 0; i < D + 6; i++) step(1'b1, W'(8'hA0 + i));
    check("R1 latency after mid-fill clear", dout, W'(8'hA0 + 6));

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule